// File: doc/BRIEF.md
# GPIO Bank Register File with Masked Half-Word Writes

This block holds the software-visible control state of a 32-pin general-purpose I/O bank. It sits on a simple memory-mapped bus with an address, write data, a write strobe and read data. Each 32-bit control register is split across two consecutive bus words. The lower word carries logical bits 15:0 and the word 4 bytes above carries bits 31:16. A write to either half carries its own per-bit write enables in bus bits 31:16. Software can therefore set or clear one pin's configuration in a single write, with no read-modify-write and no lock.

The block stores the pin output levels, pin directions, interrupt enable, mask, trigger type, polarity and dual-edge selection, and the debounce enables. A plain 24-bit debounce clock divider has its own word. Interrupt detection and debounce filtering live in neighbouring blocks: they read these registers through dedicated output ports and return their status vectors here for software to read. A write to the end-of-interrupt word is forwarded as a one-cycle clear pulse to the interrupt logic. The block also returns the sampled pin levels and a fixed version word.

Reads are combinational from the address. Writes take effect on the rising clock edge on which the write strobe is high. The low two address bits are ignored.

Top module: `gpio_mask_regfile`

## Requirements
- R1: While reset is asserted and right after it is released, every configuration output, the divider, the clear pulse and the sampled pin word are zero.
- R2: On a write to a masked half, bus bit i+16 is the write enable for data bit i (i = 0..15). A data bit takes bus bit i only when its enable is 1 and keeps its value otherwise.
- R3: The word at a register's base offset holds logical bits 15:0. The word at base+4 holds bits 31:16. A write to one half leaves the other half unchanged.
- R4: Reading a masked half returns its 16 stored bits in bus bits 15:0 and zeros in bits 31:16.
- R5: The masked registers and the ports they drive are: output level 0x00, direction 0x08 (1 = output, 0 = input), interrupt enable 0x10, interrupt mask 0x18, trigger type 0x20, polarity 0x28, dual-edge 0x30, debounce enable 0x38 and divided-clock enable 0x40.
- R6: Offset 0x48 is a plain unmasked register. A write stores bus bits 23:0, and a read returns them with bits 31:24 zero.
- R7: Offset 0x50 reads the interrupt status input and 0x58 reads the raw status input. Offset 0x70 reads the pin inputs as registered on the previous clock edge.
- R8: Offset 0x78 always reads 0x01000C2B. Writes to it change nothing.
- R9: A write to 0x60 drives the clear pulse output with the write data for exactly the next clock cycle. The output is zero in every other cycle, and reading 0x60 returns zero.
- R10: Unmapped offsets (for example 0x4C, 0x64 and 0x7C) read as zero, and writes to them leave all stored state unchanged.
- R11: A cycle without the write strobe changes no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address; bits 1:0 ignored |
| busWdata | input | 32 | Write data (masked halves: enables in 31:16, data in 15:0) |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | 32 | Combinational read data |
| pinIn | input | 32 | Pin levels from the pads |
| intStatusIn | input | 32 | Masked interrupt status from the interrupt logic |
| intRawIn | input | 32 | Unmasked interrupt status from the interrupt logic |
| outLevel | output | 32 | Pin output levels |
| outDir | output | 32 | Pin direction, 1 = output |
| intEnable | output | 32 | Interrupt enable per pin |
| intMask | output | 32 | Interrupt mask per pin |
| intType | output | 32 | Interrupt trigger type per pin |
| intPolarity | output | 32 | Interrupt polarity per pin |
| intDualEdge | output | 32 | Trigger on both edges per pin |
| dbEnable | output | 32 | Debounce enable per pin |
| dbDivEnable | output | 32 | Divided debounce clock enable per pin |
| dbDivider | output | 24 | Debounce clock divider value |
| eoiClear | output | 32 | One-cycle per-pin interrupt clear pulse |

## Verification
The bound checker checks every cycle that a low-half write to the output-level register merges data under its enables, and that the upper half holds during it. It also checks that idle cycles leave the stored registers unchanged, that the clear pulse follows only an end-of-interrupt write and carries its data, that masked-half reads have a zero upper half, and that the version word is constant. Only the bench scenarios show the rest. These are the full offset map seen through the output ports, the 24-bit truncation of the divider, the one-cycle delay of the pin sample, and the absence of effects from writes to unmapped and read-only offsets.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int NUM_MASKED = 9;
  localparam int IDX_W      = $clog2(NUM_MASKED);

  // byte offsets of the words that do not belong to the masked block
  localparam int OFF_MASK_END = 'h48;
  localparam int OFF_DIV      = 'h48;
  localparam int OFF_STAT     = 'h50;
  localparam int OFF_RAW      = 'h58;
  localparam int OFF_EOI      = 'h60;
  localparam int OFF_PIN      = 'h70;
  localparam int OFF_VER      = 'h78;

  // order of the masked registers: index = offset / 8
  localparam int IDX_LEVEL   = 0;
  localparam int IDX_DIR     = 1;
  localparam int IDX_INTEN   = 2;
  localparam int IDX_INTMASK = 3;
  localparam int IDX_TYPE    = 4;
  localparam int IDX_POL     = 5;
  localparam int IDX_DUAL    = 6;
  localparam int IDX_DBEN    = 7;
  localparam int IDX_DIVEN   = 8;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_HALF,
    RD_DIV,
    RD_STAT,
    RD_RAW,
    RD_PIN,
    RD_VER
  } rdSel_e;

  typedef struct packed {
    logic             halfWr;
    logic [IDX_W-1:0] regIdx;
    logic             upper;
    logic             divWr;
    logic             eoiWr;
    rdSel_e           rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobe
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordAddr;
  assign wordAddr = busAddr[ADDR_W-1:2];

  function automatic logic hit(input logic [WORD_W-1:0] w, input int off);
    return w == WORD_W'(off >> 2);
  endfunction

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    strobe.regIdx = IDX_W'(busAddr[ADDR_W-1:3]);
    strobe.upper  = busAddr[2];
    if (wordAddr < WORD_W'(OFF_MASK_END >> 2)) begin
      strobe.halfWr = busWe;
      strobe.rdSel  = RD_HALF;
    end else if (hit(wordAddr, OFF_DIV)) begin
      strobe.divWr = busWe;
      strobe.rdSel = RD_DIV;
    end else if (hit(wordAddr, OFF_STAT)) begin
      strobe.rdSel = RD_STAT;
    end else if (hit(wordAddr, OFF_RAW)) begin
      strobe.rdSel = RD_RAW;
    end else if (hit(wordAddr, OFF_EOI)) begin
      strobe.eoiWr = busWe;
    end else if (hit(wordAddr, OFF_PIN)) begin
      strobe.rdSel = RD_PIN;
    end else if (hit(wordAddr, OFF_VER)) begin
      strobe.rdSel = RD_VER;
    end
  end

endmodule

// File: rtl/gpio_mask_data.sv
module gpio_mask_data
  import gpio_mask_pkg::*;
#(
  parameter int          DIV_W   = 24,
  parameter logic [31:0] VERSION = 32'h01000C2B
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strobe,
  input  logic [DATA_W-1:0]                  busWdata,
  output logic [DATA_W-1:0]                  busRdata,
  input  logic [DATA_W-1:0]                  pinIn,
  input  logic [DATA_W-1:0]                  intStatusIn,
  input  logic [DATA_W-1:0]                  intRawIn,
  output logic [NUM_MASKED-1:0][DATA_W-1:0]  regOut,
  output logic [DIV_W-1:0]                   divOut,
  output logic [DATA_W-1:0]                  eoiOut
);

  logic [NUM_MASKED-1:0][DATA_W-1:0] maskedReg;
  logic [NUM_MASKED-1:0][DATA_W-1:0] maskedNext;
  logic [DIV_W-1:0]                  divReg;
  logic [DATA_W-1:0]                 pinSample;
  logic [DATA_W-1:0]                 eoiReg;

  logic [HALF_W-1:0] wrEn;
  logic [HALF_W-1:0] wrData;
  assign wrEn   = busWdata[DATA_W-1:HALF_W];
  assign wrData = busWdata[HALF_W-1:0];

  for (genvar g = 0; g < NUM_MASKED; g++) begin : gHalf
    logic sel;
    logic [HALF_W-1:0] loNew, hiNew;
    assign sel   = strobe.halfWr && (strobe.regIdx == IDX_W'(g));
    assign loNew = (maskedReg[g][HALF_W-1:0] & ~wrEn) | (wrData & wrEn);
    assign hiNew = (maskedReg[g][DATA_W-1:HALF_W] & ~wrEn) | (wrData & wrEn);
    assign maskedNext[g] = !sel ? maskedReg[g] :
                           strobe.upper ? {hiNew, maskedReg[g][HALF_W-1:0]} :
                                          {maskedReg[g][DATA_W-1:HALF_W], loNew};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskedReg <= '0;
      divReg    <= '0;
      pinSample <= '0;
      eoiReg    <= '0;
    end else begin
      maskedReg <= maskedNext;
      pinSample <= pinIn;
      eoiReg    <= strobe.eoiWr ? busWdata : '0;
      if (strobe.divWr) divReg <= busWdata[DIV_W-1:0];
    end
  end

  logic [DATA_W-1:0] halfWord;
  always_comb begin
    halfWord = '0;
    if (int'(strobe.regIdx) < NUM_MASKED) begin
      halfWord[HALF_W-1:0] = strobe.upper ? maskedReg[strobe.regIdx][DATA_W-1:HALF_W]
                                          : maskedReg[strobe.regIdx][HALF_W-1:0];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_HALF: busRdata = halfWord;
      RD_DIV:  busRdata = DATA_W'(divReg);
      RD_STAT: busRdata = intStatusIn;
      RD_RAW:  busRdata = intRawIn;
      RD_PIN:  busRdata = pinSample;
      RD_VER:  busRdata = VERSION;
      default: busRdata = '0;
    endcase
  end

  assign regOut = maskedReg;
  assign divOut = divReg;
  assign eoiOut = eoiReg;

endmodule

// File: rtl/gpio_mask_regfile.sv
module gpio_mask_regfile
  import gpio_mask_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DIV_W   = 24,
  parameter logic [31:0] VERSION = 32'h01000C2B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata,
  input  logic [31:0]       pinIn,
  input  logic [31:0]       intStatusIn,
  input  logic [31:0]       intRawIn,
  output logic [31:0]       outLevel,
  output logic [31:0]       outDir,
  output logic [31:0]       intEnable,
  output logic [31:0]       intMask,
  output logic [31:0]       intType,
  output logic [31:0]       intPolarity,
  output logic [31:0]       intDualEdge,
  output logic [31:0]       dbEnable,
  output logic [31:0]       dbDivEnable,
  output logic [DIV_W-1:0]  dbDivider,
  output logic [31:0]       eoiClear
);

  strobe_t strobe;
  logic [NUM_MASKED-1:0][DATA_W-1:0] regOut;

  gpio_mask_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_mask_data #(.DIV_W(DIV_W), .VERSION(VERSION)) dataInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .pinIn      (pinIn),
    .intStatusIn(intStatusIn),
    .intRawIn   (intRawIn),
    .regOut     (regOut),
    .divOut     (dbDivider),
    .eoiOut     (eoiClear)
  );

  assign outLevel    = regOut[IDX_LEVEL];
  assign outDir      = regOut[IDX_DIR];
  assign intEnable   = regOut[IDX_INTEN];
  assign intMask     = regOut[IDX_INTMASK];
  assign intType     = regOut[IDX_TYPE];
  assign intPolarity = regOut[IDX_POL];
  assign intDualEdge = regOut[IDX_DUAL];
  assign dbEnable    = regOut[IDX_DBEN];
  assign dbDivEnable = regOut[IDX_DIVEN];

endmodule

// File: rtl/gpio_mask_regfile_chk.sv
module gpio_mask_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWe,
  input logic [31:0]       busRdata,
  input logic [31:0]       outLevel,
  input logic [31:0]       outDir,
  input logic [31:0]       intType,
  input logic [31:0]       eoiClear
);

  logic [ADDR_W-3:0] wordAddr;
  assign wordAddr = busAddr[ADDR_W-1:2];

  logic atLevelLo, atEoi, atVer, inMasked;
  assign atLevelLo = wordAddr == '0;
  assign atEoi     = wordAddr == (ADDR_W-2)'('h60 >> 2);
  assign atVer     = wordAddr == (ADDR_W-2)'('h78 >> 2);
  assign inMasked  = wordAddr < (ADDR_W-2)'('h48 >> 2);

  // R2
  level_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && atLevelLo |=> outLevel[15:0] ==
      (($past(outLevel[15:0]) & ~$past(busWdata[31:16])) |
       ($past(busWdata[15:0]) & $past(busWdata[31:16]))));

  // R3
  other_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && atLevelLo |=> $stable(outLevel[31:16]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(outLevel) && $stable(outDir) && $stable(intType));

  // R9
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiClear != 0) |-> $past(busWe && atEoi));

  // R9
  eoi_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && atEoi |=> eoiClear == $past(busWdata));

  // R4
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    inMasked |-> busRdata[31:16] == 16'h0);

  // R8
  version_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    atVer |-> busRdata == 32'h01000C2B);

endmodule

bind gpio_mask_regfile gpio_mask_regfile_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busWe   (busWe),
  .busRdata(busRdata),
  .outLevel(outLevel),
  .outDir  (outDir),
  .intType (intType),
  .eoiClear(eoiClear)
);

// File: tb/gpio_mask_regfile_test.sv
module gpio_mask_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0, intStatusIn = '0, intRawIn = '0;
  logic [31:0] outLevel, outDir, intEnable, intMask, intType, intPolarity;
  logic [31:0] intDualEdge, dbEnable, dbDivEnable, eoiClear;
  logic [23:0] dbDivider;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  gpio_mask_regfile uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pinIn(pinIn),
    .intStatusIn(intStatusIn), .intRawIn(intRawIn), .outLevel(outLevel),
    .outDir(outDir), .intEnable(intEnable), .intMask(intMask),
    .intType(intType), .intPolarity(intPolarity), .intDualEdge(intDualEdge),
    .dbEnable(dbEnable), .dbDivEnable(dbDivEnable), .dbDivider(dbDivider),
    .eoiClear(eoiClear)
  );

  // {address, write data, expected read-back of the same address}
  localparam logic [71:0] VECS [16] = '{
    {8'h00, 32'h00FF00A5, 32'h000000A5},  // R2 low byte enabled
    {8'h00, 32'h0F00FFFF, 32'h00000FA5},  // R2 only bits 11:8 enabled
    {8'h04, 32'hFFFF1234, 32'h00001234},  // R3 upper half
    {8'h00, 32'h00010000, 32'h00000FA4},  // R2 clear bit 0
    {8'h08, 32'h8001FFFF, 32'h00008001},  // R5 direction
    {8'h10, 32'h00030003, 32'h00000003},  // R5 interrupt enable
    {8'h1C, 32'hFFFFFFFF, 32'h0000FFFF},  // R4 upper read zero
    {8'h28, 32'h0000FFFF, 32'h00000000},  // R2 no enables
    {8'h34, 32'h80008000, 32'h00008000},  // R5 dual edge
    {8'h3C, 32'hFFFFBEEF, 32'h0000BEEF},  // R5 debounce enable
    {8'h44, 32'h00030002, 32'h00000002},  // R5 divided clock enable
    {8'h24, 32'hFFFF5A5A, 32'h00005A5A},  // R5 trigger type
    {8'h48, 32'hFFABCDEF, 32'h00ABCDEF},  // R6 divider
    {8'h78, 32'hFFFFFFFF, 32'h01000C2B},  // R8 version
    {8'h60, 32'h00000000, 32'h00000000},  // R9 read zero
    {8'h64, 32'hFFFFFFFF, 32'h00000000}   // R10 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic checkPorts(input string req);
    check({req, " level"}, outLevel, 32'h12340FA4);
    check({req, " dir"}, outDir, 32'h00008001);
    check({req, " inten"}, intEnable, 32'h00000003);
    check({req, " mask"}, intMask, 32'hFFFF0000);
    check({req, " type"}, intType, 32'h5A5A0000);
    check({req, " pol"}, intPolarity, 32'h0);
    check({req, " dual"}, intDualEdge, 32'h80000000);
    check({req, " dben"}, dbEnable, 32'hBEEF0000);
    check({req, " diven"}, dbDivEnable, 32'h00020000);
    check({req, " div"}, {8'h0, dbDivider}, 32'h00ABCDEF);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    pinIn = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 level in reset", outLevel, 32'h0);
    check("R1 eoi in reset", eoiClear, 32'h0);
    busRead(8'h70, rd);
    check("R1 pin sample in reset", rd, 32'h0);
    rstN = 1'b1;
    #1;
    check("R1 dir after reset", outDir, 32'h0);
    check("R1 div after reset", {8'h0, dbDivider}, 32'h0);
    busRead(8'h3C, rd);
    check("R1 readback after reset", rd, 32'h0);
    pinIn = '0;

    for (int i = 0; i < 16; i++) begin
      busWrite(VECS[i][71:64], VECS[i][63:32]);
      busRead(VECS[i][71:64], rd);
      check($sformatf("vector %0d R2/R3/R4/R5/R6/R8/R9/R10", i), rd, VECS[i][31:0]);
    end
    busRead(8'h00, rd);
    check("R3 low half intact", rd, 32'h00000FA4);
    checkPorts("R5");

    // R10 writes to unmapped offsets
    busWrite(8'h4C, 32'hFFFFFFFF);
    busWrite(8'h7C, 32'hFFFFFFFF);
    busWrite(8'h64, 32'hFFFFFFFF);
    busRead(8'h4C, rd);
    check("R10 read 0x4C", rd, 32'h0);
    checkPorts("R10");

    // R11 no strobe, no change
    @(negedge clk);
    busAddr = 8'h00; busWdata = 32'hFFFFFFFF; busWe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    busWdata = '0;
    checkPorts("R11");

    // R9 clear pulse lasts one cycle
    busWrite(8'h60, 32'hA5A50F0F);
    check("R9 pulse data", eoiClear, 32'hA5A50F0F);
    @(negedge clk);
    check("R9 pulse gone", eoiClear, 32'h0);
    busRead(8'h60, rd);
    check("R9 read zero", rd, 32'h0);

    // R7 status words and sampled pins
    intStatusIn = 32'h0000F00D;
    intRawIn    = 32'hC0DE0001;
    busRead(8'h50, rd);
    check("R7 status", rd, 32'h0000F00D);
    busRead(8'h58, rd);
    check("R7 raw", rd, 32'hC0DE0001);
    @(negedge clk);
    pinIn = 32'h13579BDF;
    busRead(8'h70, rd);
    check("R7 pin before edge", rd, 32'h0);
    @(negedge clk);
    busRead(8'h70, rd);
    check("R7 pin after edge", rd, 32'h13579BDF);

    // R2/R3 single-bit set in the upper half of direction
    busWrite(8'h0C, 32'h00040004);
    check("R2 single bit", outDir, 32'h00048001);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule